// File: doc/BRIEF.md
# Parallel Port Sample Readout and Mailbox Interface

This block is the device end of a legacy byte-wide parallel port. The host owns four active-low control lines (strobe, autofeed, select-in, init) and a byte of write data; the device answers on an 8-bit data bus with an output enable. Two of the host lines act as a selector. Depending on their levels the device presents stored sample data from channel A, stored sample data from channel B, a one-byte mailbox, or a fixed identification byte. A local scroll-mode input swaps the stored samples for the live converter values of each channel.

Sample readout is a streaming operation. Each strobe pulse advances a readout address that points into the sample memory. The address runs from 0x4000 up to 0x7FFF and then returns to 0x4000, never to zero. The local controller can move it back to 0x4000 at any time. The mailbox is a single byte shared, half-duplex, between the host and the local controller. Whichever side wrote last sees zero, and the other side sees the byte. Because a zero read means "nothing for you", the value zero cannot be carried.

All host lines are asynchronous to the device clock. They pass through synchronizers before any decision is made, so the data bus follows a control change a few clocks later. This is well inside the roughly 200 ns the host allows for the bus to settle.

Top module: `pp_host_port`

## Requirements
- R1: Selection is decoded from the autofeed and select-in lines, low meaning asserted. Both deasserted selects channel A data. Autofeed alone asserted selects channel B data. Select-in alone asserted selects the host's view of the mailbox. Both asserted selects the constant 0x55.
- R2: While scroll_mode is 1, the channel A and channel B selections present adc_a and adc_b instead of mem_a_data and mem_b_data.
- R3: A falling strobe edge with init asserted (low) and channel A or B selected advances rd_addr by one. A falling strobe edge with init deasserted, or with the mailbox or ID selected, leaves rd_addr unchanged.
- R4: rd_addr is 0x4000 after reset and stays within 0x4000 to 0x7FFF. An advance from 0x7FFF gives 0x4000. A one-cycle addr_reload pulse sets it to 0x4000.
- R5: A falling strobe edge with init deasserted (high) and the mailbox selected stores host_wdata in the mailbox, which the controller then reads on ctl_rdata. The same edge with init asserted stores nothing.
- R6: After reset both sides read the mailbox as 0. After either side writes, that side reads 0 and the other side reads the written byte, until the other side writes. A controller write is a one-cycle ctl_wr pulse with ctl_wdata.
- R7: dev_oe is 0 while init is deasserted (high) and 1 while init is asserted (low), so the device releases the data lines during host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_strobe_n | input | 1 | Host strobe, active low; falling edge is the event |
| host_autofd_n | input | 1 | Host autofeed, active low; low bit of the selector |
| host_selin_n | input | 1 | Host select-in, active low; high bit of the selector |
| host_init_n | input | 1 | Host init, active low; high means the host drives the bus |
| host_wdata | input | 8 | Byte driven by the host during mailbox writes |
| dev_rdata | output | 8 | Byte the device presents on the data lines |
| dev_oe | output | 1 | Device output enable for the data lines |
| rd_addr | output | 15 | Sample memory readout address |
| mem_a_data | input | 8 | Stored channel A sample at rd_addr |
| mem_b_data | input | 8 | Stored channel B sample at rd_addr |
| adc_a | input | 8 | Live channel A converter value |
| adc_b | input | 8 | Live channel B converter value |
| scroll_mode | input | 1 | Present live converter values on the channel selections |
| addr_reload | input | 1 | Return rd_addr to the start of the readout window |
| ctl_wr | input | 1 | Controller mailbox write strobe |
| ctl_wdata | input | 8 | Controller mailbox write byte |
| ctl_rdata | output | 8 | Controller view of the mailbox |

## Verification
The bench pushes the readout address through a full window so that the step from 0x7FFF is seen. A counter that wrapped to zero or kept climbing would then present the wrong stored byte and the wrong address. It sends strobes that must be ignored, with init deasserted on a channel and with init asserted on the mailbox. A decoder that ignored the init line would move the address or overwrite the mailbox. It exchanges mailbox bytes in both directions, including repeated writes by one side and a zero byte, which catches a mailbox that shows the writer its own byte or loses track of which side wrote last. Selector decoding, the scroll-mode substitution and the output enable are compared against a bench model after every control change.

// File: rtl/pp_port_pkg.sv
package pp_port_pkg;

  // Source presented on the data lines, coded as {select-in asserted, autofeed asserted}
  typedef enum logic [1:0] {
    SEL_CHA  = 2'b00,
    SEL_CHB  = 2'b01,
    SEL_MBOX = 2'b10,
    SEL_ID   = 2'b11
  } port_sel_e;

  // Which side placed the current mailbox byte
  typedef enum logic [1:0] {
    MB_EMPTY = 2'b00,
    MB_HOST  = 2'b01,
    MB_CTL   = 2'b10
  } mb_owner_e;

  function automatic port_sel_e decode_sel(input logic autofd_n, input logic selin_n);
    return port_sel_e'({~selin_n, ~autofd_n});
  endfunction

endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pp_strobe_decode.sv
module pp_strobe_decode
  import pp_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_n_s,
  input  logic      init_n_s,
  input  port_sel_e sel,
  output logic      host_wr_ev,
  output logic      adv_ev
);
  logic strobe_prev_q;
  logic strobe_fall;
  logic chan_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_prev_q <= 1'b1;
    else        strobe_prev_q <= strobe_n_s;
  end

  always_comb begin
    strobe_fall = strobe_prev_q & ~strobe_n_s;
    chan_sel    = (sel == SEL_CHA) || (sel == SEL_CHB);
    host_wr_ev  = strobe_fall &  init_n_s & (sel == SEL_MBOX);
    adv_ev      = strobe_fall & ~init_n_s & chan_sel;
  end

  // R3 / R5: one edge never both advances and writes
  p_event_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr_ev && adv_ev));
  // R5: a host write only happens on a strobe edge seen after a high level
  p_wr_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_ev |-> ($past(strobe_n_s) && !strobe_n_s));
endmodule

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr #(
  parameter int                ADDR_W = 15,
  parameter logic [ADDR_W-1:0] BASE   = 15'h4000,
  parameter logic [ADDR_W-1:0] LAST   = 15'h7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              reload,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = adv | reload;
    if (reload)            addr_d = BASE;
    else if (addr_q == LAST) addr_d = BASE;
    else                   addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= BASE;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  p_addr_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q >= BASE) && (addr_q <= LAST));
  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload && addr_q == LAST) |=> (addr_q == BASE));
  p_addr_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (addr_q == BASE));
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload && addr_q != LAST) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !reload) |=> $stable(addr_q));
endmodule

// File: rtl/pp_mailbox.sv
module pp_mailbox
  import pp_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_data,
  output logic [DATA_W-1:0] host_view,
  output logic [DATA_W-1:0] ctl_view
);
  mb_owner_e         owner_q, owner_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              mb_en;

  always_comb begin
    mb_en   = host_wr | ctl_wr;
    owner_d = owner_q;
    byte_d  = byte_q;
    if (ctl_wr) begin
      owner_d = MB_CTL;
      byte_d  = ctl_data;
    end else if (host_wr) begin
      owner_d = MB_HOST;
      byte_d  = host_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= MB_EMPTY;
      byte_q  <= '0;
    end else if (mb_en) begin
      owner_q <= owner_d;
      byte_q  <= byte_d;
    end
  end

  always_comb begin
    host_view = (owner_q == MB_CTL)  ? byte_q : '0;
    ctl_view  = (owner_q == MB_HOST) ? byte_q : '0;
  end

  p_ctl_own_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_view == '0));
  p_host_own_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ctl_wr) |=> (host_view == '0));
  p_host_deliver_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ctl_wr) |=> (ctl_view == $past(host_data)));
  p_ctl_deliver_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (host_view == $past(ctl_data)));
  p_mb_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !ctl_wr) |=> ($stable(host_view) && $stable(ctl_view)));
  p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_view == '0) || (ctl_view == '0));
endmodule

// File: rtl/pp_out_mux.sv
module pp_out_mux
  import pp_port_pkg::*;
#(
  parameter int                DATA_W  = 8,
  parameter logic [DATA_W-1:0] ID_BYTE = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  port_sel_e         sel,
  input  logic              drive_req,
  input  logic              scroll,
  input  logic [DATA_W-1:0] mem_a,
  input  logic [DATA_W-1:0] mem_b,
  input  logic [DATA_W-1:0] live_a,
  input  logic [DATA_W-1:0] live_b,
  input  logic [DATA_W-1:0] mbox,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);
  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] chan_a, chan_b;

  always_comb begin
    chan_a = scroll ? live_a : mem_a;
    chan_b = scroll ? live_b : mem_b;
    unique case (sel)
      SEL_CHA:  dout_d = chan_a;
      SEL_CHB:  dout_d = chan_b;
      SEL_MBOX: dout_d = mbox;
      default:  dout_d = ID_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      dout <= dout_d;
      oe   <= drive_req;
    end
  end

  p_id_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_ID) |=> (dout == ID_BYTE));
  p_mbox_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MBOX) |=> (dout == $past(mbox)));
  p_live_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CHA && scroll) |=> (dout == $past(live_a)));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_req |=> !oe);
endmodule

// File: rtl/pp_host_port.sv
module pp_host_port
  import pp_port_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 15,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ADDR_BASE   = 15'h4000,
  parameter logic [ADDR_W-1:0] ADDR_LAST   = 15'h7FFF,
  parameter logic [DATA_W-1:0] ID_BYTE     = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_strobe_n,
  input  logic              host_autofd_n,
  input  logic              host_selin_n,
  input  logic              host_init_n,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] dev_rdata,
  output logic              dev_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] mem_a_data,
  input  logic [DATA_W-1:0] mem_b_data,
  input  logic [DATA_W-1:0] adc_a,
  input  logic [DATA_W-1:0] adc_b,
  input  logic              scroll_mode,
  input  logic              addr_reload,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata
);
  localparam int LINES_W = 4 + DATA_W;
  localparam logic [LINES_W-1:0] LINES_IDLE = {4'b1111, {DATA_W{1'b0}}};

  logic              rst_i_n;
  logic [LINES_W-1:0] lines_raw, lines_s;
  logic              strobe_n_s, autofd_n_s, selin_n_s, init_n_s;
  logic [DATA_W-1:0] wdata_s;
  port_sel_e         sel_s;
  logic              host_wr_ev, adv_ev;
  logic [DATA_W-1:0] host_view;

  pp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign lines_raw = {host_strobe_n, host_autofd_n, host_selin_n, host_init_n, host_wdata};

  pp_sync #(.W(LINES_W), .STAGES(SYNC_STAGES), .RST_VAL(LINES_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(lines_raw), .q(lines_s));

  assign {strobe_n_s, autofd_n_s, selin_n_s, init_n_s, wdata_s} = lines_s;
  assign sel_s = decode_sel(autofd_n_s, selin_n_s);

  pp_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_i_n), .strobe_n_s(strobe_n_s), .init_n_s(init_n_s),
    .sel(sel_s), .host_wr_ev(host_wr_ev), .adv_ev(adv_ev));

  pp_addr_ctr #(.ADDR_W(ADDR_W), .BASE(ADDR_BASE), .LAST(ADDR_LAST)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .adv(adv_ev), .reload(addr_reload), .addr(rd_addr));

  pp_mailbox #(.DATA_W(DATA_W)) u_mbox (
    .clk(clk), .rst_n(rst_i_n), .host_wr(host_wr_ev), .host_data(wdata_s),
    .ctl_wr(ctl_wr), .ctl_data(ctl_wdata), .host_view(host_view), .ctl_view(ctl_rdata));

  pp_out_mux #(.DATA_W(DATA_W), .ID_BYTE(ID_BYTE)) u_mux (
    .clk(clk), .rst_n(rst_i_n), .sel(sel_s), .drive_req(~init_n_s),
    .scroll(scroll_mode), .mem_a(mem_a_data), .mem_b(mem_b_data),
    .live_a(adc_a), .live_b(adc_b), .mbox(host_view),
    .dout(dev_rdata), .oe(dev_oe));

  // R7: the bus is released whenever the host has taken it for a write
  p_oe_follows_init_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    init_n_s |=> !dev_oe);
  p_oe_drive_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !init_n_s |=> dev_oe);
endmodule

// File: tb/sim_pp_host_port.sv
module sim_pp_host_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe_n = 1'b1, autofd_n = 1'b1, selin_n = 1'b1, init_n = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] dev_rdata, ctl_rdata;
  logic dev_oe;
  logic [14:0] rd_addr;
  logic [7:0] mem_a, mem_b;
  logic [7:0] adc_a = 8'h00, adc_b = 8'h00;
  logic scroll = 1'b0, reload = 1'b0, ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;

  int n_chk = 0, n_fail = 0;
  logic [14:0] exp_addr = 15'h4000;
  int mb_owner = 0;            // 0 empty, 1 host wrote last, 2 controller wrote last
  logic [7:0] mb_byte = '0;
  int cur_sel = 0;             // 0 A, 1 B, 2 mailbox, 3 ID

  always #2.5 clk = ~clk;

  function automatic logic [7:0] fa(input logic [14:0] a);
    return a[7:0] ^ a[14:7];
  endfunction
  function automatic logic [7:0] fb(input logic [14:0] a);
    return ~a[7:0] + a[14:8];
  endfunction
  function automatic logic [14:0] next_addr(input logic [14:0] a);
    return (a == 15'h7FFF) ? 15'h4000 : a + 15'd1;
  endfunction
  function automatic logic [7:0] exp_out(input int s);
    case (s)
      0: return scroll ? adc_a : fa(exp_addr);
      1: return scroll ? adc_b : fb(exp_addr);
      2: return (mb_owner == 2) ? mb_byte : 8'h00;
      default: return 8'h55;
    endcase
  endfunction

  assign mem_a = fa(rd_addr);
  assign mem_b = fb(rd_addr);

  pp_host_port u0 (
    .clk(clk), .rst_n(rst_n), .host_strobe_n(strobe_n), .host_autofd_n(autofd_n),
    .host_selin_n(selin_n), .host_init_n(init_n), .host_wdata(wdata),
    .dev_rdata(dev_rdata), .dev_oe(dev_oe), .rd_addr(rd_addr),
    .mem_a_data(mem_a), .mem_b_data(mem_b), .adc_a(adc_a), .adc_b(adc_b),
    .scroll_mode(scroll), .addr_reload(reload), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // s: 0 A, 1 B, 2 mailbox, 3 ID; autofeed is bit 0, select-in bit 1 (asserted = low)
  task automatic set_lines(input int s, input logic init_lvl);
    @(negedge clk);
    autofd_n = ~s[0];
    selin_n  = ~s[1];
    init_n   = init_lvl;
    cur_sel  = s;
    settle();
  endtask

  task automatic pulse();
    strobe_n = 1'b0;
    repeat (2) @(negedge clk);
    strobe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_bus(input string req);
    chk(req, {24'h0, dev_rdata}, {24'h0, exp_out(cur_sel)});
  endtask

  task automatic host_write(input logic [7:0] v);
    set_lines(2, 1'b1);
    wdata = v;
    pulse();
    settle();
    mb_owner = 1; mb_byte = v;
    chk("R7 oe low during host write", {31'h0, dev_oe}, 32'h0);
    chk("R5 controller sees host byte", {24'h0, ctl_rdata}, {24'h0, v});
    set_lines(2, 1'b0);
    check_bus("R6 host reads own write as zero");
  endtask

  task automatic ctl_write(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
    settle();
    mb_owner = 2; mb_byte = v;
    chk("R6 controller reads own write as zero", {24'h0, ctl_rdata}, 32'h0);
    set_lines(2, 1'b0);
    check_bus("R6 host sees controller byte");
  endtask

  task automatic do_reload();
    @(negedge clk);
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
    exp_addr = 15'h4000;
    settle();
    chk("R4 reload to window start", {17'h0, rd_addr}, {17'h0, exp_addr});
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // reset state
    chk("R4 reset address", {17'h0, rd_addr}, 32'h4000);
    chk("R6 controller view empty after reset", {24'h0, ctl_rdata}, 32'h0);
    chk("R7 oe low with init high", {31'h0, dev_oe}, 32'h0);
    set_lines(2, 1'b0);
    chk("R7 oe high with init low", {31'h0, dev_oe}, 32'h1);
    check_bus("R6 host view empty after reset");

    // R1 each selection
    for (int s = 0; s < 4; s++) begin
      set_lines(s, 1'b0);
      check_bus($sformatf("R1 select %0d", s));
    end

    // R3 advance and ignored strobes
    set_lines(0, 1'b0);
    pulse(); exp_addr = next_addr(exp_addr); settle();
    chk("R3 advance on channel A", {17'h0, rd_addr}, {17'h0, exp_addr});
    check_bus("R3 data follows address A");
    set_lines(1, 1'b0);
    pulse(); exp_addr = next_addr(exp_addr); settle();
    check_bus("R3 data follows address B");
    set_lines(0, 1'b1);
    pulse(); settle();
    chk("R3 strobe ignored with init high", {17'h0, rd_addr}, {17'h0, exp_addr});
    set_lines(3, 1'b0);
    pulse(); settle();
    chk("R3 strobe ignored on ID select", {17'h0, rd_addr}, {17'h0, exp_addr});
    set_lines(2, 1'b0);
    pulse(); settle();
    chk("R3 strobe ignored on mailbox select", {17'h0, rd_addr}, {17'h0, exp_addr});

    // R4 full window and wrap
    do_reload();
    set_lines(0, 1'b0);
    for (int i = 0; i < 16383; i++) pulse();
    exp_addr = 15'h7FFF;
    settle();
    chk("R4 reach window end", {17'h0, rd_addr}, 32'h7FFF);
    check_bus("R4 data at window end");
    pulse(); exp_addr = next_addr(exp_addr); settle();
    chk("R4 wrap to 0x4000", {17'h0, rd_addr}, 32'h4000);
    check_bus("R4 data after wrap");

    // R5/R6 mailbox directed
    host_write(8'h3C);
    host_write(8'hA7);
    ctl_write(8'h81);
    ctl_write(8'h00);
    set_lines(2, 1'b0);
    wdata = 8'hEE;
    pulse(); settle();
    chk("R5 strobe with init low stores nothing", {24'h0, ctl_rdata}, 32'h0);
    check_bus("R5 host view unchanged");
    host_write(8'h00);
    chk("R6 zero byte looks empty", {24'h0, ctl_rdata}, 32'h0);

    // R2 scroll mode
    scroll = 1'b1; adc_a = 8'h9D; adc_b = 8'h12;
    set_lines(0, 1'b0); check_bus("R2 live channel A");
    set_lines(1, 1'b0); check_bus("R2 live channel B");
    scroll = 1'b0;
    settle(); check_bus("R2 stored channel B restored");

    // constrained random mix
    for (int it = 0; it < 250; it++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0, 1: begin
          int k;
          k = int'($urandom % 4);
          set_lines(op, 1'b0);
          for (int j = 0; j < k; j++) begin
            pulse(); exp_addr = next_addr(exp_addr);
          end
          settle();
          chk("R3 random readout address", {17'h0, rd_addr}, {17'h0, exp_addr});
          check_bus("R1 random readout data");
        end
        2: host_write(8'($urandom % 255 + 1));
        3: ctl_write(8'($urandom % 255 + 1));
        4: begin
          scroll = $urandom % 2 == 1;
          adc_a = 8'($urandom); adc_b = 8'($urandom);
          set_lines(int'($urandom % 4), 1'b0);
          check_bus("R2 random scroll select");
        end
        default: do_reload();
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule